// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC. When a frame's 48-bit destination address is known, the parser presents it on `da` and pulses `da_valid` for one clock. Exactly one clock later the filter pulses `dec_valid` and drives `dec_accept` high if the frame is to be kept. The handshake has no backpressure, so a new address may arrive on every clock.

Software programs the filter through a simple write port. The port reaches eight exact-match entries, a 64-bin multicast hash table and a control word. Entry 0 is meant for the station's own address. The other entries hold extra unicast or multicast addresses.

Each entry is split into two words. Writing the low word turns the entry off. Writing the high word turns it back on. Software therefore writes the low word first and the high word last, and a half-written address can never match.

A frame whose address misses every entry is still accepted in three cases:
- it is a multicast frame whose hash bin is set;
- it is a broadcast frame, unless broadcast is disabled;
- copy-all mode is on.

The hash index is a 6-bit XOR fold of all 48 address bits.

Internally, a two-state machine tracks the decision slot:
- `ST_IDLE`: no decision is presented.
- `ST_RESULT`: a decision is presented this cycle.

Its transitions are named as follows:
- IDLE→RESULT on a strobe ("lookup").
- RESULT→RESULT on a back-to-back strobe ("chain").
- RESULT→IDLE when there is no strobe ("retire").
- IDLE→IDLE otherwise ("wait").

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low and every entry is disabled. The hash table and the control word are all zero. A unicast address is therefore rejected and the broadcast address is accepted.
- R2: Every cycle with `da_valid` high is followed, in the next cycle, by exactly one cycle of `dec_valid` high, including strobes on back-to-back cycles. `dec_valid` is low in every other cycle, and `dec_accept` is never high while `dec_valid` is low.
- R3: Address byte k (the k-th byte on the wire) is `da[8k+7:8k]`. Entry i has its low word at write address 2i and its high word at 2i+1. The low word holds bytes 0 to 3 in bits 31:0, byte 0 lowest. The high word holds byte 4 in bits 7:0 and byte 5 in bits 15:8.
- R4: An address equal to the stored address of any enabled entry (0 to 7) is accepted.
- R5: Writing an entry's low word disables that entry, and writing its high word enables it. A disabled entry never causes acceptance.
- R6: The hash index bit j is the XOR of every address bit `da[k]` with k mod 6 = j, for k from 0 to 47.
- R7: The hash table bins 0 to 31 are bits 31:0 at write address 16, and bins 32 to 63 are bits 31:0 at address 17. A multicast address that is not broadcast is accepted when hash matching is enabled and the bin it indexes is set. When hash matching is disabled, the table has no effect.
- R8: A frame is multicast when `da[0]` is 1. A unicast frame is never accepted through the hash table, even when all bins are set.
- R9: The all-ones address is accepted unless broadcast-disable is set, and the hash table is not consulted for it.
- R10: The control word is at write address 18: bit 0 is copy-all, bit 1 is hash-multicast enable, bit 2 is broadcast disable. While copy-all is set, every address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision strobe, one clock after `da_valid` |
| dec_accept | output | 1 | High with `dec_valid` when the frame is kept |

## Verification
The embedded assertions check, on every cycle:
- the one-clock strobe relation and the absence of stray accepts;
- that copy-all and enabled broadcast always accept;
- that a unicast miss is always rejected;
- that low-word and high-word writes clear and set an entry's enable.

Only the bench's scenarios can show that a stored address lands in the intended byte lanes, that the hash index selects the right bin in each table half, and that disabling broadcast overrides an all-ones table. It also covers the interplay of all the sources under random programming.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    parameter int MAC_W     = 48;
    parameter int WORD_W    = 32;
    parameter int HASH_W    = 6;
    parameter int HASH_BINS = 1 << HASH_W;

    typedef struct packed {
        logic bcast_dis;
        logic hash_en;
        logic copy_all;
    } rxaf_ctrl_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rxaf_state_t;

endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int CFG_AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [CFG_AW-1:0]       waddr,
    input  logic [WORD_W-1:0]       wdata,
    output logic [N_ENT-1:0][MAC_W-1:0] ent_mac,
    output logic [N_ENT-1:0]        ent_en,
    output logic [HASH_BINS-1:0]    hash_tbl,
    output rxaf_ctrl_t              ctrl
);

    localparam int HI_W          = MAC_W - WORD_W;
    localparam int HASH_LO_INDEX = 2 * N_ENT;
    localparam int HASH_HI_INDEX = 2 * N_ENT + 1;
    localparam int CTRL_INDEX    = 2 * N_ENT + 2;

    logic unused_wdata_bits;
    assign unused_wdata_bits = &wdata[WORD_W-1:HI_W];

    genvar gi;
    generate
        for (gi = 0; gi < N_ENT; gi++) begin : g_ent
            localparam logic [CFG_AW-1:0] LO_A = CFG_AW'(2 * gi);
            localparam logic [CFG_AW-1:0] HI_A = CFG_AW'(2 * gi + 1);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_mac[gi] <= '0;
                    ent_en[gi]  <= 1'b0;
                end else if (we && waddr == LO_A) begin
                    ent_mac[gi][WORD_W-1:0] <= wdata;
                    ent_en[gi]              <= 1'b0;
                end else if (we && waddr == HI_A) begin
                    ent_mac[gi][MAC_W-1:WORD_W] <= wdata[HI_W-1:0];
                    ent_en[gi]                  <= 1'b1;
                end
            end

            // R5: a low-word write leaves the entry disabled
            assert_low_write_disables_R5 : assert property (
                @(posedge clk) disable iff (!rst_n)
                (we && waddr == LO_A) |=> !ent_en[gi]);

            // R5: a high-word write leaves the entry enabled
            assert_high_write_enables_R5 : assert property (
                @(posedge clk) disable iff (!rst_n)
                (we && waddr == HI_A) |=> ent_en[gi]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_tbl <= '0;
            ctrl     <= '0;
        end else if (we) begin
            if (waddr == CFG_AW'(HASH_LO_INDEX))
                hash_tbl[WORD_W-1:0] <= wdata;
            if (waddr == CFG_AW'(HASH_HI_INDEX))
                hash_tbl[HASH_BINS-1:WORD_W] <= wdata;
            if (waddr == CFG_AW'(CTRL_INDEX))
                ctrl <= rxaf_ctrl_t'(wdata[2:0]);
        end
    end

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
(
    input  logic [MAC_W-1:0]  mac,
    output logic [HASH_W-1:0] idx
);

    // R6: fold all address bits, byte 0 first and LSB first, onto HASH_W bits
    always_comb begin
        idx = '0;
        for (int k = 0; k < MAC_W; k++)
            idx[k % HASH_W] = idx[k % HASH_W] ^ mac[k];
    end

endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
    import rxaf_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic [MAC_W-1:0]            mac,
    input  logic [N_ENT-1:0][MAC_W-1:0] ent_mac,
    input  logic [N_ENT-1:0]            ent_en,
    output logic                        hit
);

    logic [N_ENT-1:0] hit_vec;

    genvar gi;
    generate
        for (gi = 0; gi < N_ENT; gi++) begin : g_cmp
            assign hit_vec[gi] = ent_en[gi] && (ent_mac[gi] == mac);
        end
    endgenerate

    assign hit = |hit_vec;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic [47:0]       da,
    output logic              dec_valid,
    output logic              dec_accept
);

    logic [N_ENT-1:0][MAC_W-1:0] ent_mac;
    logic [N_ENT-1:0]            ent_en;
    logic [HASH_BINS-1:0]        hash_tbl;
    rxaf_ctrl_t                  ctrl;
    logic [HASH_W-1:0]           hidx;
    logic                        exact_hit;
    logic                        is_bcast, is_mcast, hash_ok, accept_d, accept_q;
    rxaf_state_t                 state, state_nx;

    rxaf_regs #(.N_ENT(N_ENT), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .ent_mac(ent_mac), .ent_en(ent_en),
        .hash_tbl(hash_tbl), .ctrl(ctrl)
    );

    rxaf_hash u_hash (.mac(da), .idx(hidx));

    rxaf_match #(.N_ENT(N_ENT)) u_match (
        .mac(da), .ent_mac(ent_mac), .ent_en(ent_en), .hit(exact_hit)
    );

    // R8, R9: classify the address
    assign is_bcast = &da;
    assign is_mcast = da[0];
    assign hash_ok  = is_mcast && !is_bcast && ctrl.hash_en && hash_tbl[hidx];
    assign accept_d = ctrl.copy_all || exact_hit || hash_ok ||
                      (is_bcast && !ctrl.bcast_dis);

    always_ff @(posedge clk) begin
        if (!rst_n) accept_q <= 1'b0;
        else if (da_valid) accept_q <= accept_d;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: lookup, chain, retire, wait
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = da_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = da_valid ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        dec_valid  = 1'b0;
        dec_accept = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_RESULT: begin
                dec_valid  = 1'b1;
                dec_accept = accept_q;
            end
            default:   ;
        endcase
    end

    assert_dec_follows_strobe_R2 : assert property (
        @(posedge clk) disable iff (!rst_n)
        da_valid |=> dec_valid);

    assert_no_spurious_dec_R2 : assert property (
        @(posedge clk) disable iff (!rst_n)
        !da_valid |=> !dec_valid);

    assert_no_stray_accept_R2 : assert property (
        @(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    assert_copy_all_accepts_R10 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (da_valid && ctrl.copy_all) |=> dec_accept);

    assert_bcast_accepts_R9 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (da_valid && (&da) && !ctrl.bcast_dis) |=> dec_accept);

    assert_unicast_miss_drops_R8 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (da_valid && !da[0] && !exact_hit && !ctrl.copy_all) |=> !dec_accept);

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        dec_valid, dec_accept;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] m_ent [8];
    bit          m_en  [8];
    logic [63:0] m_tbl;
    logic [2:0]  m_ctrl;

    always #2.5 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 48; k++) h[k % 6] ^= a[k];
        return h;
    endfunction

    function automatic bit ref_accept(input logic [47:0] a);
        bit hit = 0;
        bit bc = &a;
        for (int i = 0; i < 8; i++) if (m_en[i] && m_ent[i] == a) hit = 1;
        return m_ctrl[0] || hit || (bc && !m_ctrl[2]) ||
               (a[0] && !bc && m_ctrl[1] && m_tbl[ref_hash(a)]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 16) begin
            if (a[0]) begin m_ent[a/2][47:32] = d[15:0]; m_en[a/2] = 1; end
            else      begin m_ent[a/2][31:0]  = d;       m_en[a/2] = 0; end
        end else if (a == 16) m_tbl[31:0]  = d;
        else if (a == 17)     m_tbl[63:32] = d;
        else if (a == 18)     m_ctrl = d[2:0];
    endtask

    task automatic set_entry(input int i, input logic [47:0] mac);
        wr(6'(2*i), mac[31:0]);
        wr(6'(2*i+1), {16'h0, mac[47:32]});
    endtask

    task automatic look(input string req, input logic [47:0] a, input bit exp);
        @(negedge clk);
        da_valid = 1'b1; da = a;
        @(negedge clk);
        da_valid = 1'b0;
        check(req, {31'b0, dec_valid}, 32'd1);
        check(req, {31'b0, dec_accept}, {31'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] mc, pool [8];
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin m_ent[i] = '0; m_en[i] = 0; end
        m_tbl = '0; m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid idle", {31'b0, dec_valid}, 0);
        look("R1 unicast rejected", 48'h0000_5544_3322, 0);
        look("R9 bcast after reset", 48'hFFFF_FFFF_FFFF, 1);

        // R3, R4: entry 0 byte lanes
        set_entry(0, 48'h0605_0403_0200);
        look("R4 entry0 hit", 48'h0605_0403_0200, 1);
        look("R3 byte5 differs", 48'h0705_0403_0200, 0);
        wr(6'd0, 32'h0403_0200);
        look("R5 low write disables", 48'h0605_0403_0200, 0);
        wr(6'd1, 32'h0000_0605);
        look("R5 high write enables", 48'h0605_0403_0200, 1);
        set_entry(7, 48'hA1B2_C3D4_E5F7);
        look("R4 entry7 multicast hit", 48'hA1B2_C3D4_E5F7, 1);

        // R6, R7: byte0 bit0 only -> bin 1; bits 0 and 5 -> bin 33
        wr(6'd16, 32'h0000_0002);
        look("R7 hash disabled", 48'h0000_0000_0001, 0);
        wr(6'd18, 32'h2);
        look("R6 bin1 low half", 48'h0000_0000_0001, 1);
        look("R6 bin33 not set", 48'h0000_0000_0021, 0);
        wr(6'd17, 32'h0000_0002);
        look("R7 bin33 high half", 48'h0000_0000_0021, 1);
        wr(6'd16, 32'hFFFF_FFFF); wr(6'd17, 32'hFFFF_FFFF);
        look("R7 all ones multicast", 48'h1234_5678_9ABD, 1);
        look("R8 unicast ignores hash", 48'h1234_5678_9ABC, 0);
        wr(6'd18, 32'h6);
        look("R9 bcast disabled", 48'hFFFF_FFFF_FFFF, 0);
        wr(6'd18, 32'h5);
        look("R10 copy all unicast", 48'h0BAD_0BAD_0BAC, 1);
        look("R10 copy all bcast", 48'hFFFF_FFFF_FFFF, 1);
        wr(6'd18, 32'h0);

        // R2: back-to-back strobes then a gap
        @(negedge clk);
        da_valid = 1'b1; da = 48'h0605_0403_0200;
        @(negedge clk);
        check("R2 b2b first valid", {31'b0, dec_valid}, 1);
        check("R2 b2b first acc", {31'b0, dec_accept}, 1);
        da = 48'h0000_0000_0002;
        @(negedge clk);
        check("R2 b2b second valid", {31'b0, dec_valid}, 1);
        check("R2 b2b second acc", {31'b0, dec_accept}, 0);
        da = 48'hFFFF_FFFF_FFFF;
        @(negedge clk);
        da_valid = 1'b0;
        check("R2 b2b third acc", {31'b0, dec_accept}, 1);
        @(negedge clk);
        check("R2 gap no valid", {31'b0, dec_valid}, 0);

        // Random programming and lookups
        for (int i = 0; i < 8; i++) pool[i] = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
        for (int it = 0; it < 400; it++) begin
            int sel = $urandom_range(0, 9);
            if (sel == 0) begin
                int e = $urandom_range(0, 7);
                set_entry(e, pool[$urandom_range(0, 7)]);
            end else if (sel == 1) begin
                wr(6'($urandom_range(0, 7) * 2), $urandom());
            end else if (sel == 2) begin
                wr(6'($urandom_range(16, 17)), $urandom());
            end else if (sel == 3) begin
                wr(6'd18, 32'($urandom_range(0, 7)) & 32'h6);
            end else begin
                logic [47:0] a;
                case ($urandom_range(0, 3))
                    0: a = pool[$urandom_range(0, 7)];
                    1: a = 48'hFFFF_FFFF_FFFF;
                    2: begin mc = {$urandom(), $urandom()}; a = mc | 48'h1; end
                    default: a = {$urandom(), $urandom()};
                endcase
                look("R4 R7 R9 random", a, ref_accept(a));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule